// File: doc/BRIEF.md
# Multi-lane SPI write sequencer

This block is a transmit-only serial flash style master. One request sends a command word, then an address word, then a run of 32-bit data words. Each phase goes out on a single lane (D0) or on four lanes (D3..D0), and the lane mode decides which phases use how many lanes. Chip enable stays asserted from the first command bit to the last data bit, so the three phases form one framed transfer.

Data words are written into a small word store through a load port before the transfer starts. The request then supplies the command word, the address word and a byte count, and the block turns that count into a number of 32-bit words. The command and address lengths are programmable. A field shorter than 32 bits is left-justified, so its significant bits leave first. The serial clock is the system clock divided by twice a programmable top value. The idle level and the launch edge follow a two-bit clock mode.

Configuration inputs are captured on every cycle while the block is idle and are frozen while it is busy. A one-cycle done pulse marks the release of chip enable.

Top module: `lane_write_seq`

## Requirements
- R1: After reset, chip enable is inactive (high for the default active-low setting), sclk is low, dq_o and dq_oe are 0, and busy and done are 0.
- R2: Each serial clock period lasts 2*T system cycles, where T is cfg_div_top (0 is treated as 1), and each half lasts T cycles. busy stays high for exactly 2*T*N cycles, where N is the number of serial clocks in the transfer.
- R3: A transfer sends the command field, then the address field, then the data words, MSB first. A field of L bits (cfg_cmd_bits or cfg_addr_bits, 1..32; 0 or above 32 means 32) sends bits L-1..0 of its request word and ignores the bits above them.
- R4: cfg_lane_mode selects the lanes per phase. 0 and 3: every phase on one lane. 1: command and address on one lane, data on four. 2: every phase on four lanes. A one-lane clock drives dq_oe=4'b0001 with the bit on dq_o[0]. A four-lane clock drives dq_oe=4'b1111 and carries 4 bits, with dq_o[3] as the most significant of the nibble.
- R5: The data word count is (req_bytes-1)/4+1. A req_bytes of 0 sends one word, and a count above 4*MAX_WORDS sends MAX_WORDS words. Word i is the word last loaded at index i.
- R6: cfg_ce_high=1 makes chip enable active-high, and 0 makes it active-low. Chip enable holds its active level on every busy cycle, with no gap between phases, and is at the inactive level whenever the block is idle.
- R7: cfg_clk_mode[1] sets the idle sclk level. cfg_clk_mode[0]=0 keeps the first half of each bit period at the idle level, and 1 drives the active level in the first half. The data lanes change only at bit-period boundaries, so the mid-period edge is the sampling edge.
- R8: On the cycle busy falls, done is high for exactly one cycle, chip enable goes inactive, sclk returns to idle, and dq_o and dq_oe return to 0.
- R9: req_valid and ld_valid are ignored while busy. Configuration changes made while busy do not affect the transfer in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_lane_mode | input | 2 | Lane mode per phase (see R4) |
| cfg_ce_high | input | 1 | 1 = chip enable active-high |
| cfg_clk_mode | input | 2 | Bit 1 idle level, bit 0 launch phase |
| cfg_cmd_bits | input | 6 | Command field length in bits |
| cfg_addr_bits | input | 6 | Address field length in bits |
| cfg_div_top | input | TOP_W | Half-period length in system cycles |
| ld_valid | input | 1 | Write one data word into the store |
| ld_idx | input | IDX_W | Store index for ld_word |
| ld_word | input | 32 | Data word to store |
| req_valid | input | 1 | Start a transfer |
| req_cmd | input | 32 | Command word (low cfg_cmd_bits used) |
| req_addr | input | 32 | Address word (low cfg_addr_bits used) |
| req_bytes | input | BYTE_W | Data length in bytes |
| sclk | output | 1 | Serial clock |
| ce | output | 1 | Chip enable |
| dq_o | output | 4 | Data lanes D3..D0 |
| dq_oe | output | 4 | Per-lane output enables |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |

## Verification
The embedded assertions check on every cycle that chip enable holds its active level while busy and that the phases advance only from command to address to data. They also check that the enable pattern is one of the three legal shapes, that the lanes stay constant between bit boundaries, that the divider counter stays below the top value, and that done is a single pulse coinciding with the fall of busy. Only the bench scenarios can show that the serial bit stream equals the left-justified fields and the stored words in order, that the lane count per phase matches each lane mode, and that the byte count rounds to the right number of words. The same holds for transfer length in cycles against the divider, and for the effect of requests, loads and configuration changes issued during a transfer.

// File: rtl/lws_pkg.sv
// Shared types and helpers for the lane write sequencer.
// Assumes 32-bit words and at most four data lanes.
package lws_pkg;

    localparam int WORD_W = 32;
    localparam int LANES  = 4;

    typedef enum logic [1:0] {
        LM_SINGLE    = 2'd0,
        LM_DATA_QUAD = 2'd1,
        LM_ALL_QUAD  = 2'd2,
        LM_RSVD      = 2'd3
    } lane_mode_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_CMD  = 2'd1,
        PH_ADDR = 2'd2,
        PH_DATA = 2'd3
    } phase_e;

    // Legal field length: 0 or over 32 becomes 32.
    function automatic logic [5:0] fit_len(input logic [5:0] bits);
        return (bits == 6'd0 || bits > 6'd32) ? 6'd32 : bits;
    endfunction

    // Moves an L-bit field to the top of the word; bits above L drop out.
    function automatic logic [WORD_W-1:0] left_justify(input logic [WORD_W-1:0] w,
                                                       input logic [5:0] bits);
        logic [5:0] amt;
        amt = 6'd32 - bits;
        return w << amt;
    endfunction

    // Serial clocks needed for a field of the given length.
    function automatic logic [5:0] field_clocks(input logic [5:0] bits, input logic quad);
        return quad ? {2'b00, bits[5:2]} : bits;
    endfunction

endpackage

// File: rtl/lws_clkdiv.sv
// Serial clock generator. Counts T system cycles per half period while
// run is high and flags the last cycle of each bit period.
// Assumes top >= 1 and that top, idle_lvl and launch_lead stay stable while run is high.
module lws_clkdiv #(
    parameter int TOP_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [TOP_W-1:0] top,
    input  logic             idle_lvl,
    input  logic             launch_lead,
    output logic             sclk,
    output logic             bit_end
);

    logic [TOP_W-1:0] cnt_q;
    logic             half_q;
    logic             half_last;

    assign half_last = (cnt_q == top - TOP_W'(1));

    // Half-period counter and half flag.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q  <= '0;
            half_q <= 1'b0;
        end else if (half_last) begin
            cnt_q  <= '0;
            half_q <= ~half_q;
        end else begin
            cnt_q  <= cnt_q + TOP_W'(1);
        end
    end

    // Clock level: idle outside a transfer, otherwise the level for the current half.
    always_comb begin
        if (!run)
            sclk = idle_lvl;
        else
            sclk = idle_lvl ^ (half_q ? ~launch_lead : launch_lead);
    end

    assign bit_end = run && half_q && half_last;

    AST_DIV_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt_q < top)); // R2

    AST_HALF_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && !$past(half_last)) |-> $stable(half_q)); // R2

endmodule

// File: rtl/lws_word_store.sv
// Holds the data words of the next transfer. Writes are dropped while
// lock is high or the index is out of range; the read port is combinational.
module lws_word_store #(
    parameter int DEPTH = 8,
    parameter int IDX_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lock,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [31:0]       wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [31:0]       rd_data
);

    logic [31:0] mem [DEPTH];

    // Word writes, blocked while a transfer runs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (wr_en && !lock && int'(wr_idx) < DEPTH) begin
            mem[wr_idx] <= wr_data;
        end
    end

    assign rd_data = (int'(rd_idx) < DEPTH) ? mem[rd_idx] : '0;

endmodule

// File: rtl/lws_shifter.sv
// Output shift register. Presents the top bit (one lane) or the top nibble
// (four lanes) and shifts by the lane count on advance. Clear zeroes the
// lanes and drops the enables. Assumes load, advance and clear are exclusive.
module lws_shifter
    import lws_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] load_word,
    input  logic              load_quad,
    input  logic              advance,
    input  logic              clear,
    output logic [LANES-1:0]  lanes,
    output logic [LANES-1:0]  lane_oe
);

    logic [WORD_W-1:0] sh_q;
    logic              quad_q;
    logic              en_q;

    // Shift register, lane width and enable state.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            sh_q   <= '0;
            quad_q <= 1'b0;
            en_q   <= 1'b0;
        end else if (load) begin
            sh_q   <= load_word;
            quad_q <= load_quad;
            en_q   <= 1'b1;
        end else if (advance) begin
            sh_q   <= quad_q ? (sh_q << LANES) : (sh_q << 1);
        end
    end

    // Lane 0 carries the single-lane bit; upper lanes carry the nibble in four-lane mode.
    assign lanes[0]   = en_q & (quad_q ? sh_q[WORD_W-LANES] : sh_q[WORD_W-1]);
    assign lane_oe[0] = en_q;

    for (genvar k = 1; k < LANES; k++) begin : g_lane
        assign lanes[k]   = en_q & quad_q & sh_q[WORD_W-LANES+k];
        assign lane_oe[k] = en_q & quad_q;
    end

    AST_LANES_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && $past(en_q) && !$past(load) && !$past(advance)) |-> $stable(lanes)); // R7

endmodule

// File: rtl/lane_write_seq.sv
// Transmit-only multi-lane serial write sequencer. Sequences the command,
// address and data phases, picks the lane count per phase and frames the
// transfer with chip enable. Configuration is sampled on every idle cycle
// and frozen while busy. Assumes four-lane field lengths are multiples of 4.
module lane_write_seq
    import lws_pkg::*;
#(
    parameter int MAX_WORDS = 8,
    parameter int TOP_W     = 8,
    localparam int IDX_W    = (MAX_WORDS > 1) ? $clog2(MAX_WORDS) : 1,
    localparam int CNT_W    = $clog2(MAX_WORDS + 1) + 1,
    localparam int BYTE_W   = $clog2(MAX_WORDS * 4 + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cfg_lane_mode,
    input  logic              cfg_ce_high,
    input  logic [1:0]        cfg_clk_mode,
    input  logic [5:0]        cfg_cmd_bits,
    input  logic [5:0]        cfg_addr_bits,
    input  logic [TOP_W-1:0]  cfg_div_top,
    input  logic              ld_valid,
    input  logic [IDX_W-1:0]  ld_idx,
    input  logic [31:0]       ld_word,
    input  logic              req_valid,
    input  logic [31:0]       req_cmd,
    input  logic [31:0]       req_addr,
    input  logic [BYTE_W-1:0] req_bytes,
    output logic              sclk,
    output logic              ce,
    output logic [3:0]        dq_o,
    output logic [3:0]        dq_oe,
    output logic              busy,
    output logic              done
);

    phase_e           phase_q;
    logic             busy_q, done_q, ce_q;
    lane_mode_e       mode_q;
    logic             act_lvl_q;
    logic [1:0]       clkmode_q;
    logic [TOP_W-1:0] top_q;
    logic [5:0]       cmd_bits_q, addr_bits_q;
    logic [31:0]      addr_q;
    logic [CNT_W-1:0] nwords_q, widx_q, next_idx;
    logic [5:0]       left_q;
    logic [CNT_W-1:0] req_words;
    logic             accept, bit_end;
    logic             hdr_quad, data_quad;
    logic [IDX_W-1:0] rd_idx;
    logic [31:0]      rd_word;
    logic             sh_load, sh_quad, sh_adv, sh_clear;
    logic [31:0]      sh_word;

    assign accept    = req_valid && !busy_q;
    assign hdr_quad  = (mode_q == LM_ALL_QUAD);
    assign data_quad = (mode_q == LM_ALL_QUAD) || (mode_q == LM_DATA_QUAD);
    assign next_idx  = widx_q + CNT_W'(1);
    assign rd_idx    = (phase_q == PH_DATA) ? next_idx[IDX_W-1:0] : '0;

    // Byte count to word count, with both ends clamped.
    always_comb begin
        if (req_bytes == '0)
            req_words = CNT_W'(1);
        else if (int'(req_bytes) > MAX_WORDS * 4)
            req_words = CNT_W'(MAX_WORDS);
        else
            req_words = CNT_W'(((int'(req_bytes) - 1) >> 2) + 1);
    end

    // Configuration capture: follows the inputs while idle, frozen while busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q      <= LM_SINGLE;
            act_lvl_q   <= 1'b0;
            clkmode_q   <= 2'b00;
            top_q       <= TOP_W'(4);
            cmd_bits_q  <= 6'd32;
            addr_bits_q <= 6'd32;
        end else if (!busy_q) begin
            mode_q      <= lane_mode_e'(cfg_lane_mode);
            act_lvl_q   <= cfg_ce_high;
            clkmode_q   <= cfg_clk_mode;
            top_q       <= (cfg_div_top == '0) ? TOP_W'(1) : cfg_div_top;
            cmd_bits_q  <= fit_len(cfg_cmd_bits);
            addr_bits_q <= fit_len(cfg_addr_bits);
        end
    end

    // Shifter commands for the start, each bit end and each field boundary.
    always_comb begin
        sh_load  = 1'b0;
        sh_word  = '0;
        sh_quad  = 1'b0;
        sh_adv   = 1'b0;
        sh_clear = 1'b0;
        if (accept) begin
            sh_load = 1'b1;
            sh_word = left_justify(req_cmd, fit_len(cfg_cmd_bits));
            sh_quad = (cfg_lane_mode == LM_ALL_QUAD);
        end else if (bit_end) begin
            if (left_q > 6'd1) begin
                sh_adv = 1'b1;
            end else begin
                case (phase_q)
                    PH_CMD: begin
                        sh_load = 1'b1;
                        sh_word = left_justify(addr_q, addr_bits_q);
                        sh_quad = hdr_quad;
                    end
                    PH_ADDR: begin
                        sh_load = 1'b1;
                        sh_word = rd_word;
                        sh_quad = data_quad;
                    end
                    PH_DATA: begin
                        if (next_idx < nwords_q) begin
                            sh_load = 1'b1;
                            sh_word = rd_word;
                            sh_quad = data_quad;
                        end else begin
                            sh_clear = 1'b1;
                        end
                    end
                    default: sh_clear = 1'b1;
                endcase
            end
        end
    end

    // Phase sequencing, chip enable framing and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q  <= PH_IDLE;
            busy_q   <= 1'b0;
            done_q   <= 1'b0;
            ce_q     <= 1'b1;
            addr_q   <= '0;
            nwords_q <= '0;
            widx_q   <= '0;
            left_q   <= '0;
        end else begin
            done_q <= 1'b0;
            if (accept) begin
                phase_q  <= PH_CMD;
                busy_q   <= 1'b1;
                ce_q     <= cfg_ce_high;
                addr_q   <= req_addr;
                nwords_q <= req_words;
                widx_q   <= '0;
                left_q   <= field_clocks(fit_len(cfg_cmd_bits), cfg_lane_mode == LM_ALL_QUAD);
            end else if (!busy_q) begin
                ce_q <= ~cfg_ce_high;
            end else if (bit_end) begin
                if (left_q > 6'd1) begin
                    left_q <= left_q - 6'd1;
                end else begin
                    case (phase_q)
                        PH_CMD: begin
                            phase_q <= PH_ADDR;
                            left_q  <= field_clocks(addr_bits_q, hdr_quad);
                        end
                        PH_ADDR: begin
                            phase_q <= PH_DATA;
                            widx_q  <= '0;
                            left_q  <= data_quad ? 6'd8 : 6'd32;
                        end
                        default: begin
                            if (next_idx < nwords_q) begin
                                widx_q <= next_idx;
                                left_q <= data_quad ? 6'd8 : 6'd32;
                            end else begin
                                phase_q <= PH_IDLE;
                                busy_q  <= 1'b0;
                                done_q  <= 1'b1;
                                ce_q    <= ~act_lvl_q;
                            end
                        end
                    endcase
                end
            end
        end
    end

    lws_clkdiv #(.TOP_W(TOP_W)) u_div (
        .clk         (clk),
        .rst_n       (rst_n),
        .run         (busy_q),
        .top         (top_q),
        .idle_lvl    (clkmode_q[1]),
        .launch_lead (clkmode_q[0]),
        .sclk        (sclk),
        .bit_end     (bit_end)
    );

    lws_word_store #(.DEPTH(MAX_WORDS), .IDX_W(IDX_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .lock    (busy_q),
        .wr_en   (ld_valid),
        .wr_idx  (ld_idx),
        .wr_data (ld_word),
        .rd_idx  (rd_idx),
        .rd_data (rd_word)
    );

    lws_shifter u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (sh_load),
        .load_word (sh_word),
        .load_quad (sh_quad),
        .advance   (sh_adv),
        .clear     (sh_clear),
        .lanes     (dq_o),
        .lane_oe   (dq_oe)
    );

    assign ce   = ce_q;
    assign busy = busy_q;
    assign done = done_q;

    AST_CE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> (ce_q == act_lvl_q)); // R6

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q); // R8

    AST_DONE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> (!busy_q && $past(busy_q))); // R8

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_q |-> (dq_oe == 4'b0000 && dq_o == 4'b0000)); // R8

    AST_OE_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        (dq_oe == 4'b0000 || dq_oe == 4'b0001 || dq_oe == 4'b1111)); // R4

    AST_HDR_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && phase_q != PH_DATA && !hdr_quad) |-> (dq_oe == 4'b0001)); // R4

    AST_PHASE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && $past(busy_q) && phase_q != $past(phase_q)) |->
        ((phase_q == PH_ADDR && $past(phase_q) == PH_CMD) ||
         (phase_q == PH_DATA && $past(phase_q) == PH_ADDR))); // R3

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && $past(busy_q)) |-> ($stable(top_q) && $stable(mode_q) && $stable(clkmode_q))); // R9

endmodule

// File: tb/tb_lane_write_seq.sv
`timescale 1ns/1ps
module tb_lane_write_seq;

    localparam int MAXW = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cfg_lane_mode = 2'd0;
    logic        cfg_ce_high = 1'b0;
    logic [1:0]  cfg_clk_mode = 2'd0;
    logic [5:0]  cfg_cmd_bits = 6'd32;
    logic [5:0]  cfg_addr_bits = 6'd32;
    logic [7:0]  cfg_div_top = 8'd4;
    logic        ld_valid = 1'b0;
    logic [2:0]  ld_idx = '0;
    logic [31:0] ld_word = '0;
    logic        req_valid = 1'b0;
    logic [31:0] req_cmd = '0;
    logic [31:0] req_addr = '0;
    logic [5:0]  req_bytes = '0;
    logic        sclk, ce, busy, done;
    logic [3:0]  dq_o, dq_oe;

    lane_write_seq #(.MAX_WORDS(MAXW), .TOP_W(8)) dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_lane_mode(cfg_lane_mode), .cfg_ce_high(cfg_ce_high),
        .cfg_clk_mode(cfg_clk_mode), .cfg_cmd_bits(cfg_cmd_bits),
        .cfg_addr_bits(cfg_addr_bits), .cfg_div_top(cfg_div_top),
        .ld_valid(ld_valid), .ld_idx(ld_idx), .ld_word(ld_word),
        .req_valid(req_valid), .req_cmd(req_cmd), .req_addr(req_addr),
        .req_bytes(req_bytes),
        .sclk(sclk), .ce(ce), .dq_o(dq_o), .dq_oe(dq_oe),
        .busy(busy), .done(done)
    );

    always #5 clk = ~clk;

    int n_checks = 0;
    int n_fail   = 0;
    bit ended    = 1'b0;

    logic [31:0] wmodel [MAXW];

    // Monitor state
    bit   cap  [1024];
    bit   expb [1024];
    int   ncap, nsingle, nquad, nbadoe, busy_cyc, done_cnt, ce_err;
    logic exp_act  = 1'b0;
    logic samp_lvl = 1'b1;
    logic prev_sclk = 1'b0;

    // Captures lanes on the mid-period edge and tracks framing.
    always @(negedge clk) begin
        if (busy === 1'b1) begin
            busy_cyc++;
            if (ce !== exp_act) ce_err++;
            if (sclk !== prev_sclk && sclk === samp_lvl) begin
                if (dq_oe == 4'b0001) begin
                    if (ncap < 1024) cap[ncap] = dq_o[0];
                    ncap++;
                    nsingle++;
                end else if (dq_oe == 4'b1111) begin
                    for (int k = 3; k >= 0; k--) begin
                        if (ncap < 1024) cap[ncap] = dq_o[k];
                        ncap++;
                    end
                    nquad++;
                end else begin
                    nbadoe++;
                end
            end
        end
        if (done === 1'b1) done_cnt++;
        prev_sclk = sclk;
    end

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        #1500000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run did not end (actual hung, expected finished)");
        finish_run();
    end

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic set_cfg(input logic [1:0] mode, input logic [1:0] clkm, input logic ceh,
                           input logic [7:0] top, input logic [5:0] cb, input logic [5:0] ab);
        cfg_lane_mode = mode;
        cfg_clk_mode  = clkm;
        cfg_ce_high   = ceh;
        cfg_div_top   = top;
        cfg_cmd_bits  = cb;
        cfg_addr_bits = ab;
        tick();
        tick();
    endtask

    task automatic load_word(input int idx, input logic [31:0] w);
        ld_valid = 1'b1;
        ld_idx   = 3'(idx);
        ld_word  = w;
        tick();
        ld_valid = 1'b0;
        wmodel[idx] = w;
    endtask

    task automatic start(input logic [31:0] cmd, input logic [31:0] addr, input int bytes);
        ncap = 0; nsingle = 0; nquad = 0; nbadoe = 0;
        busy_cyc = 0; done_cnt = 0; ce_err = 0;
        exp_act  = cfg_ce_high;
        samp_lvl = cfg_clk_mode[1] ^ ~cfg_clk_mode[0];
        req_cmd   = cmd;
        req_addr  = addr;
        req_bytes = 6'(bytes);
        req_valid = 1'b1;
        tick();
        req_valid = 1'b0;
    endtask

    task automatic wait_end();
        int n = 0;
        while (busy === 1'b1 && n < 20000) begin
            tick();
            n++;
        end
        tick();
        tick();
    endtask

    // Compares one finished transfer against the model built from the requirements.
    task automatic check_xfer(input string tag, input int mode, input int clkm, input int ceh,
                              input int top, input int cb, input int ab,
                              input logic [31:0] cmd, input logic [31:0] addr, input int bytes);
        int nw, ne, es, eq, bad;
        bit hq, dqd;
        nw  = (bytes == 0) ? 1 : ((bytes > 4 * MAXW) ? MAXW : ((bytes - 1) / 4 + 1));
        hq  = (mode == 2);
        dqd = (mode == 1 || mode == 2);
        ne = 0;
        for (int i = cb - 1; i >= 0; i--) begin expb[ne] = cmd[i]; ne++; end
        for (int i = ab - 1; i >= 0; i--) begin expb[ne] = addr[i]; ne++; end
        for (int w = 0; w < nw; w++)
            for (int i = 31; i >= 0; i--) begin expb[ne] = wmodel[w][i]; ne++; end
        es = (hq ? 0 : cb + ab) + (dqd ? 0 : 32 * nw);
        eq = (hq ? (cb + ab) / 4 : 0) + (dqd ? 8 * nw : 0);
        bad = -1;
        for (int i = 0; i < ne && i < ncap; i++)
            if (bad < 0 && cap[i] != expb[i]) bad = i;
        chk(ncap == ne, "R5", {tag, " bit count"}, ncap, ne);
        chk(bad < 0, "R3", {tag, " first mismatching bit index"}, bad, -1);
        chk(nsingle == es, "R4", {tag, " one-lane clocks"}, nsingle, es);
        chk(nquad == eq, "R4", {tag, " four-lane clocks"}, nquad, eq);
        chk(nbadoe == 0, "R4", {tag, " illegal enable samples"}, nbadoe, 0);
        chk(busy_cyc == 2 * top * (es + eq), "R2", {tag, " busy cycles"}, busy_cyc, 2 * top * (es + eq));
        chk(ce_err == 0, "R6", {tag, " chip enable drops while busy"}, ce_err, 0);
        chk(done_cnt == 1, "R8", {tag, " done pulses"}, done_cnt, 1);
        chk(dq_o == 4'b0 && dq_oe == 4'b0, "R8", {tag, " lanes after end"}, {dq_oe, dq_o}, 0);
        chk(sclk == 1'(clkm >> 1), "R7", {tag, " idle clock level"}, sclk, clkm >> 1);
        chk(ce == ~1'(ceh), "R6", {tag, " chip enable after end"}, ce, ~ceh & 1);
        chk(busy == 1'b0, "R8", {tag, " busy after end"}, busy, 0);
    endtask

    task automatic test_reset();
        chk(ce == 1'b1, "R1", "reset chip enable", ce, 1);
        chk(sclk == 1'b0, "R1", "reset sclk", sclk, 0);
        chk(dq_o == 4'b0 && dq_oe == 4'b0, "R1", "reset lanes", {dq_oe, dq_o}, 0);
        chk(busy == 1'b0 && done == 1'b0, "R1", "reset busy/done", {busy, done}, 0);
    endtask

    task automatic test_single_default();
        set_cfg(2'd0, 2'd0, 1'b0, 8'd4, 6'd32, 6'd32);
        load_word(0, 32'h5A0F_C381);
        load_word(1, 32'h1E2D_3C4B);
        start(32'h9C3A_51F0, 32'h0012_3456, 8);
        wait_end();
        check_xfer("single", 0, 0, 0, 4, 32, 32, 32'h9C3A_51F0, 32'h0012_3456, 8);
    endtask

    task automatic test_data_quad();
        set_cfg(2'd1, 2'd1, 1'b0, 8'd2, 6'd8, 6'd24);
        load_word(0, 32'hF00D_1234);
        load_word(1, 32'h8421_7BDE);
        load_word(2, 32'h0000_00FF);
        start(32'hFFFF_FF6B, 32'hAB0F_1E2D, 9);
        wait_end();
        check_xfer("data-quad", 1, 1, 0, 2, 8, 24, 32'hFFFF_FF6B, 32'hAB0F_1E2D, 9);
    endtask

    task automatic test_all_quad();
        set_cfg(2'd2, 2'd3, 1'b1, 8'd1, 6'd8, 6'd24);
        chk(ce == 1'b0, "R6", "active-high idle chip enable", ce, 0);
        chk(sclk == 1'b1, "R7", "mode 3 idle clock", sclk, 1);
        load_word(0, 32'hC0DE_9A71);
        start(32'h0000_00E3, 32'h0070_8090, 1);
        wait_end();
        check_xfer("all-quad", 2, 3, 1, 1, 8, 24, 32'h0000_00E3, 32'h0070_8090, 1);
    endtask

    task automatic test_reserved_mode();
        set_cfg(2'd3, 2'd2, 1'b0, 8'd3, 6'd16, 6'd16);
        load_word(0, 32'h1357_9BDF);
        load_word(1, 32'h2468_ACE0);
        start(32'h7777_B00C, 32'h1234_00AA, 5);
        wait_end();
        check_xfer("mode3", 0, 2, 0, 3, 16, 16, 32'h7777_B00C, 32'h1234_00AA, 5);
    endtask

    task automatic test_ignore_while_busy();
        int extra;
        set_cfg(2'd0, 2'd0, 1'b0, 8'd2, 6'd8, 6'd8);
        load_word(0, 32'h6B6B_0101);
        start(32'h0000_0042, 32'h0000_0099, 4);
        for (int i = 0; i < 10; i++) tick();
        req_valid = 1'b1; req_cmd = 32'hFFFF_FFFF; req_bytes = 6'd32;
        ld_valid = 1'b1; ld_idx = 3'd0; ld_word = 32'hDEAD_BEEF;
        cfg_div_top = 8'd7; cfg_lane_mode = 2'd2;
        tick();
        req_valid = 1'b0; ld_valid = 1'b0;
        wait_end();
        cfg_div_top = 8'd2; cfg_lane_mode = 2'd0;
        check_xfer("busy-req", 0, 0, 0, 2, 8, 8, 32'h0000_0042, 32'h0000_0099, 4);
        extra = 0;
        for (int i = 0; i < 20; i++) begin
            tick();
            if (busy) extra++;
        end
        chk(extra == 0, "R9", "request during busy started a transfer", extra, 0);
        start(32'h0000_00C3, 32'h0000_0011, 2);
        wait_end();
        check_xfer("busy-load", 0, 0, 0, 2, 8, 8, 32'h0000_00C3, 32'h0000_0011, 2);
    endtask

    task automatic test_byte_rounding();
        set_cfg(2'd1, 2'd0, 1'b0, 8'd1, 6'd4, 6'd4);
        for (int i = 0; i < MAXW; i++) load_word(i, 32'h0101_0101 * (i + 3) ^ 32'hA5C3_0000);
        start(32'h0000_0009, 32'h0000_0006, 32);
        wait_end();
        check_xfer("bytes32", 1, 0, 0, 1, 4, 4, 32'h0000_0009, 32'h0000_0006, 32);
        start(32'h0000_0003, 32'h0000_000C, 12);
        wait_end();
        check_xfer("bytes12", 1, 0, 0, 1, 4, 4, 32'h0000_0003, 32'h0000_000C, 12);
    endtask

    initial begin
        for (int i = 0; i < MAXW; i++) wmodel[i] = '0;
        for (int i = 0; i < 4; i++) tick();
        rst_n = 1'b1;
        tick();
        test_reset();
        test_single_default();
        test_data_quad();
        test_all_quad();
        test_reserved_mode();
        test_ignore_while_busy();
        test_byte_rounding();
        finish_run();
    end

endmodule